// File: doc/BRIEF.md
# PLL Coefficient Reprogramming Sequencer

This block moves a clock PLL from its present divider coefficients (reference divider M, feedback divider N, post divider PL) to a new set without letting the output clock glitch or overshoot. A start request carries the target coefficients and a flag that permits sliding. When sliding is permitted, the PLL is running and only N changes, the block asks an external ramp controller to glide N to the new value. Otherwise it takes the relock path. First, if it can, it glides N down to a safe low value. It then halves the output with a temporary 1:2 divider and parks the clock on bypass. It powers the PLL up, writes the coefficients while the PLL is disabled, re-enables it and waits for lock under a timeout. After lock it returns to the VCO and restores 1:1. When sliding is permitted it finishes by gliding N up to the target.

If any step of an attempt that was allowed to slide fails, the whole sequence runs again with sliding forbidden. A separate disable request glides N down, selects bypass and turns the PLL off. The lock and ramp timeouts are counted in microseconds from a prescaled tick.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the PLL is disabled (`pll_en_o`=0) and powered down (`pll_iddq_o`=1), with lock detection off (`pll_lockdet_off_o`=1), bypass selected (`pll_vco_sel_o`=0), divider field 0 and coefficient word 0. `ramp_req_o`, `busy_o`, `done_o` and `err_o` are all 0.
- R2: When sliding is allowed, the PLL is enabled and the new M and PL equal those in the coefficient word, the block only requests a ramp to the new N and then ends. It makes no request at all if N is already equal, and the PLL is never disabled on this path.
- R3: A ramp request holds `ramp_req_o` high with a steady `ramp_n_o` until `ramp_done_i` or `ramp_err_i` arrives or the ramp timeout expires. The N field of the coefficient word takes the ramp target in the cycle the request rises, and N changes in no other way while the PLL is enabled.
- R4: On the relock path with sliding allowed and the PLL enabled, N is first ramped to n_lo(M_old) = min(255, ceil(M_old*MIN_VCO_MHZ/REF_MHZ)). The ramp is skipped if N already holds that value.
- R5: Before bypass, the divider field is set to 2 (output 1:2). Bypass is selected (`pll_vco_sel_o`=0), power-down is cleared and the PLL is disabled, all before it is enabled again.
- R6: The coefficient word (M in bits 7:0, N in bits 15:8, PL in bits 21:16) changes M or PL only while the PLL is disabled. On the relock path it is written with the new M and PL, and with N = n_lo(new M) when sliding or the target N otherwise. The PLL is then enabled and lock-detect-off is cleared.
- R7: After enabling, the block waits for `pll_lock_i`. Only then does it reselect the VCO, still at divider field 2, and afterwards sets the divider field to 0 (1:1).
- R8: With sliding allowed, the relock path ends by ramping N up to the target N, skipped if it is already there.
- R9: A ramp error, a ramp timeout or a lock timeout in a slide-allowed attempt reruns the whole sequence with sliding forbidden, and a success then leaves `err_o` at 0.
- R10: A lock timeout in a no-slide attempt ends the sequence with `done_o` and sets `err_o`. `err_o` is sticky and clears only when the next start is accepted.
- R11: A disable request from idle ramps N to n_lo(current M) if the PLL is enabled (skipped if equal). It then selects bypass, clears the enable, and ends with `done_o`. If the PLL was already disabled, no ramp is requested.
- R12: `busy_o` is high from the accepted request until the end. `done_o` is a single-cycle pulse with `busy_o` low. Start and disable requests arriving while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to reprogram to the target coefficients |
| slide_ok_i | input | 1 | Sliding of N permitted for this request |
| tgt_m_i | input | 8 | Target reference divider M |
| tgt_n_i | input | 8 | Target feedback divider N |
| tgt_pl_i | input | 6 | Target post divider code PL |
| disable_i | input | 1 | Request to run the disable sequence |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| ramp_done_i | input | 1 | Ramp controller finished the requested N glide |
| ramp_err_i | input | 1 | Ramp controller reports a failed glide |
| pll_en_o | output | 1 | PLL enable |
| pll_iddq_o | output | 1 | PLL power-down |
| pll_lockdet_off_o | output | 1 | Lock detector disable |
| pll_vco_sel_o | output | 1 | 1 selects VCO output, 0 selects bypass clock |
| vco_div_o | output | 6 | Output divider field: 0 is 1:1, 2 is 1:2 |
| coeff_o | output | 22 | Coefficient word {PL, N, M} |
| ramp_req_o | output | 1 | Ramp request to the ramp controller |
| ramp_n_o | output | 8 | N value the ramp must reach |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sticky failure flag |

## Verification
On every cycle, the assertions check the ordering invariants. M and PL move only while the PLL is off, and N moves only at a ramp request while it is on. The PLL is enabled only from bypass with the 1:2 divider, and the VCO is reselected only under lock. A ramp request stays stable until it ends, `done_o` is a lone pulse outside busy, and `err_o` falls only on a start. Which path a request takes can only be shown by the bench's scenarios: the ramp targets, the coefficient value written at enable, the retry after each kind of failure, and the sticky error. The bench sweeps M, PL and the slide flag against a modelled PLL and ramp controller.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the PLL reprogramming sequencer.
// Assumes the coefficient word layout {PL, N, M} with fixed field positions,
// because the PLL itself decodes those positions.
package pll_seq_pkg;
    localparam int M_W     = 8;
    localparam int N_W     = 8;
    localparam int PL_W    = 6;
    localparam int DIV_W   = 6;
    localparam int M_LSB   = 0;
    localparam int N_LSB   = 8;
    localparam int PL_LSB  = 16;
    localparam int COEFF_W = PL_LSB + PL_W;

    localparam logic [DIV_W-1:0] DIV_1TO1 = DIV_W'(0);
    localparam logic [DIV_W-1:0] DIV_1TO2 = DIV_W'(2);

    typedef enum logic [4:0] {
        ST_IDLE, ST_CHECK, ST_R_SETUP, ST_RAMP, ST_SET_DIV2, ST_BYPASS,
        ST_CLR_IDDQ, ST_PWR_OFF, ST_WR_COEFF, ST_PWR_ON, ST_CLR_LDO,
        ST_LOCK_WAIT, ST_SEL_VCO, ST_DIV1, ST_FINISH, ST_D_BYP, ST_D_OFF
    } seq_state_t;

    typedef enum logic [1:0] {
        RK_FAST, RK_DOWN, RK_UP, RK_DIS
    } ramp_kind_t;
endpackage

// File: rtl/pll_seq_nlo.sv
`timescale 1ns/1ps
// Computes the lowest safe N for a given M: ceil(M*MIN_VCO_MHZ/REF_MHZ),
// saturated to the N field. Purely combinational; assumes REF_MHZ > 0.
module pll_seq_nlo
    import pll_seq_pkg::*;
#(
    parameter int REF_MHZ     = 12,
    parameter int MIN_VCO_MHZ = 1000
) (
    input  logic [M_W-1:0] m_i,
    output logic [N_W-1:0] n_lo_o
);
    localparam logic [31:0] REF_L   = 32'(REF_MHZ);
    localparam logic [31:0] VCO_L   = 32'(MIN_VCO_MHZ);
    localparam logic [31:0] N_MAX_L = 32'((1 << N_W) - 1);

    logic [31:0] prod;
    logic [31:0] quot;

    // Rounded-up division followed by saturation to the field width.
    always_comb begin
        prod   = 32'(m_i) * VCO_L;
        quot   = (prod + REF_L - 32'd1) / REF_L;
        n_lo_o = (quot > N_MAX_L) ? N_MAX_L[N_W-1:0] : quot[N_W-1:0];
    end
endmodule

// File: rtl/pll_seq_timer.sv
`timescale 1ns/1ps
// Microsecond timeout counter. A prescaler turns CYC_PER_US clocks into one
// tick; the tick count is compared to the lock or ramp limit. Everything
// clears whenever run_i is low, so each wait starts from zero.
module pll_seq_timer #(
    parameter int CYC_PER_US  = 200,
    parameter int LOCK_TMO_US = 300000,
    parameter int RAMP_TMO_US = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic sel_lock_i,
    output logic expired_o
);
    localparam int MAX_TMO = (LOCK_TMO_US > RAMP_TMO_US) ? LOCK_TMO_US : RAMP_TMO_US;
    localparam int US_W    = $clog2(MAX_TMO + 1);
    localparam int PRE_W   = $clog2(CYC_PER_US + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
    localparam logic [US_W-1:0]  LIM_LOCK = US_W'(LOCK_TMO_US);
    localparam logic [US_W-1:0]  LIM_RAMP = US_W'(RAMP_TMO_US);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_q;
    logic             tick;
    logic [US_W-1:0]  limit;

    assign tick      = (pre_q == PRE_LAST);
    assign limit     = sel_lock_i ? LIM_LOCK : LIM_RAMP;
    assign expired_o = run_i && (us_q >= limit);

    // Prescaler: one tick per microsecond while a wait is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) pre_q <= '0;
        else if (tick)        pre_q <= '0;
        else                  pre_q <= pre_q + PRE_W'(1);
    end

    // Microsecond count, held once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)             us_q <= '0;
        else if (tick && (us_q < limit))  us_q <= us_q + US_W'(1);
    end
endmodule

// File: rtl/pll_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencing state machine. Chooses between the N-only slide and the
// bypass-and-relock path, drives every PLL control register, hands N glides
// to the ramp controller and reruns without sliding after a failed attempt.
// Assumes n_lo values arrive combinationally for the current and new M.
module pll_seq_ctrl
    import pll_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               slide_ok_i,
    input  logic [M_W-1:0]     tgt_m_i,
    input  logic [N_W-1:0]     tgt_n_i,
    input  logic [PL_W-1:0]    tgt_pl_i,
    input  logic               disable_i,
    input  logic               pll_lock_i,
    input  logic               ramp_done_i,
    input  logic               ramp_err_i,
    input  logic [N_W-1:0]     nlo_cur_i,
    input  logic [N_W-1:0]     nlo_new_i,
    input  logic               tmo_i,
    output logic               tmr_run_o,
    output logic               tmr_lock_o,
    output logic [M_W-1:0]     cur_m_o,
    output logic [M_W-1:0]     new_m_o,
    output logic               pll_en_o,
    output logic               pll_iddq_o,
    output logic               pll_lockdet_off_o,
    output logic               pll_vco_sel_o,
    output logic [DIV_W-1:0]   vco_div_o,
    output logic [COEFF_W-1:0] coeff_o,
    output logic               ramp_req_o,
    output logic [N_W-1:0]     ramp_n_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    seq_state_t          state_q;
    ramp_kind_t          kind_q;
    logic                slide_q;
    logic [M_W-1:0]      m_q;
    logic [N_W-1:0]      n_q;
    logic [PL_W-1:0]     pl_q;
    logic [COEFF_W-1:0]  coeff_q;
    logic [N_W-1:0]      ramp_n_q;
    logic                en_q, iddq_q, ldo_q, vsel_q, done_q, err_q;
    logic [DIV_W-1:0]    div_q;

    logic [M_W-1:0]      cur_m;
    logic [N_W-1:0]      cur_n;
    logic [PL_W-1:0]     cur_pl;
    logic [N_W-1:0]      ramp_val;
    logic                fast_ok;

    // Field views of the live coefficient word.
    assign cur_m  = coeff_q[M_LSB +: M_W];
    assign cur_n  = coeff_q[N_LSB +: N_W];
    assign cur_pl = coeff_q[PL_LSB +: PL_W];

    // N-only slide is possible when only N differs on a running PLL.
    assign fast_ok = slide_q && en_q && (m_q == cur_m) && (pl_q == cur_pl);

    // Ramp target: the final N for the slide and the climb, otherwise the low N.
    assign ramp_val = (kind_q == RK_FAST || kind_q == RK_UP) ? n_q : nlo_cur_i;

    // Where a successful ramp of each kind continues.
    function automatic seq_state_t after_ramp(input ramp_kind_t k);
        case (k)
            RK_DOWN: after_ramp = ST_SET_DIV2;
            RK_DIS:  after_ramp = ST_D_BYP;
            default: after_ramp = ST_FINISH;
        endcase
    endfunction

    // Main sequencing register set: state, latched targets and PLL controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= RK_FAST;
            slide_q  <= 1'b0;
            m_q      <= '0;
            n_q      <= '0;
            pl_q     <= '0;
            coeff_q  <= '0;
            ramp_n_q <= '0;
            en_q     <= 1'b0;
            iddq_q   <= 1'b1;
            ldo_q    <= 1'b1;
            vsel_q   <= 1'b0;
            div_q    <= DIV_1TO1;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        m_q     <= tgt_m_i;
                        n_q     <= tgt_n_i;
                        pl_q    <= tgt_pl_i;
                        slide_q <= slide_ok_i;
                        err_q   <= 1'b0;
                        state_q <= ST_CHECK;
                    end else if (disable_i) begin
                        kind_q  <= RK_DIS;
                        state_q <= en_q ? ST_R_SETUP : ST_D_BYP;
                    end
                end
                ST_CHECK: begin
                    if (fast_ok) begin
                        kind_q  <= RK_FAST;
                        state_q <= ST_R_SETUP;
                    end else if (slide_q && en_q) begin
                        kind_q  <= RK_DOWN;
                        state_q <= ST_R_SETUP;
                    end else begin
                        state_q <= ST_SET_DIV2;
                    end
                end
                ST_R_SETUP: begin
                    if (ramp_val == cur_n) begin
                        state_q <= after_ramp(kind_q);
                    end else begin
                        coeff_q[N_LSB +: N_W] <= ramp_val;
                        ramp_n_q              <= ramp_val;
                        state_q               <= ST_RAMP;
                    end
                end
                ST_RAMP: begin
                    if (ramp_done_i) begin
                        state_q <= after_ramp(kind_q);
                    end else if (ramp_err_i || tmo_i) begin
                        if (kind_q == RK_DIS) begin
                            state_q <= ST_D_BYP;
                        end else if (slide_q) begin
                            slide_q <= 1'b0;
                            state_q <= ST_CHECK;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_FINISH;
                        end
                    end
                end
                ST_SET_DIV2: begin
                    div_q   <= DIV_1TO2;
                    state_q <= ST_BYPASS;
                end
                ST_BYPASS: begin
                    vsel_q  <= 1'b0;
                    state_q <= ST_CLR_IDDQ;
                end
                ST_CLR_IDDQ: begin
                    iddq_q  <= 1'b0;
                    state_q <= ST_PWR_OFF;
                end
                ST_PWR_OFF: begin
                    en_q    <= 1'b0;
                    state_q <= ST_WR_COEFF;
                end
                ST_WR_COEFF: begin
                    coeff_q <= {pl_q, (slide_q ? nlo_new_i : n_q), m_q};
                    state_q <= ST_PWR_ON;
                end
                ST_PWR_ON: begin
                    en_q    <= 1'b1;
                    state_q <= ST_CLR_LDO;
                end
                ST_CLR_LDO: begin
                    ldo_q   <= 1'b0;
                    state_q <= ST_LOCK_WAIT;
                end
                ST_LOCK_WAIT: begin
                    if (pll_lock_i) begin
                        state_q <= ST_SEL_VCO;
                    end else if (tmo_i) begin
                        if (slide_q) begin
                            slide_q <= 1'b0;
                            state_q <= ST_CHECK;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_FINISH;
                        end
                    end
                end
                ST_SEL_VCO: begin
                    vsel_q  <= 1'b1;
                    state_q <= ST_DIV1;
                end
                ST_DIV1: begin
                    div_q <= DIV_1TO1;
                    if (slide_q) begin
                        kind_q  <= RK_UP;
                        state_q <= ST_R_SETUP;
                    end else begin
                        state_q <= ST_FINISH;
                    end
                end
                ST_D_BYP: begin
                    vsel_q  <= 1'b0;
                    state_q <= ST_D_OFF;
                end
                ST_D_OFF: begin
                    en_q    <= 1'b0;
                    state_q <= ST_FINISH;
                end
                ST_FINISH: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tmr_run_o         = (state_q == ST_RAMP) || (state_q == ST_LOCK_WAIT);
    assign tmr_lock_o        = (state_q == ST_LOCK_WAIT);
    assign cur_m_o           = cur_m;
    assign new_m_o           = m_q;
    assign pll_en_o          = en_q;
    assign pll_iddq_o        = iddq_q;
    assign pll_lockdet_off_o = ldo_q;
    assign pll_vco_sel_o     = vsel_q;
    assign vco_div_o         = div_q;
    assign coeff_o           = coeff_q;
    assign ramp_req_o        = (state_q == ST_RAMP);
    assign ramp_n_o          = ramp_n_q;
    assign busy_o            = (state_q != ST_IDLE);
    assign done_o            = done_q;
    assign err_o             = err_q;
endmodule

// File: rtl/pll_reprog_seq.sv
`timescale 1ns/1ps
// Top of the PLL reprogramming sequencer. Wires the state machine to two
// n_lo calculators (current M and new M) and the microsecond timeout timer.
// Assumes the ramp controller answers a request with a done or error pulse.
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int REF_MHZ     = 12,
    parameter int MIN_VCO_MHZ = 1000,
    parameter int CYC_PER_US  = 200,
    parameter int LOCK_TMO_US = 300000,
    parameter int RAMP_TMO_US = 500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               slide_ok_i,
    input  logic [M_W-1:0]     tgt_m_i,
    input  logic [N_W-1:0]     tgt_n_i,
    input  logic [PL_W-1:0]    tgt_pl_i,
    input  logic               disable_i,
    input  logic               pll_lock_i,
    input  logic               ramp_done_i,
    input  logic               ramp_err_i,
    output logic               pll_en_o,
    output logic               pll_iddq_o,
    output logic               pll_lockdet_off_o,
    output logic               pll_vco_sel_o,
    output logic [DIV_W-1:0]   vco_div_o,
    output logic [COEFF_W-1:0] coeff_o,
    output logic               ramp_req_o,
    output logic [N_W-1:0]     ramp_n_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    localparam int NLO_CNT = 2;

    logic [M_W-1:0] nlo_m [NLO_CNT];
    logic [N_W-1:0] nlo_n [NLO_CNT];
    logic           tmr_run, tmr_lock, tmo;
    logic [M_W-1:0] cur_m, new_m;

    assign nlo_m[0] = cur_m;
    assign nlo_m[1] = new_m;

    // One n_lo calculator per M source: index 0 current, index 1 new.
    for (genvar g = 0; g < NLO_CNT; g++) begin : g_nlo
        pll_seq_nlo #(
            .REF_MHZ     (REF_MHZ),
            .MIN_VCO_MHZ (MIN_VCO_MHZ)
        ) u_nlo (
            .m_i    (nlo_m[g]),
            .n_lo_o (nlo_n[g])
        );
    end

    pll_seq_timer #(
        .CYC_PER_US  (CYC_PER_US),
        .LOCK_TMO_US (LOCK_TMO_US),
        .RAMP_TMO_US (RAMP_TMO_US)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (tmr_run),
        .sel_lock_i (tmr_lock),
        .expired_o  (tmo)
    );

    pll_seq_ctrl u_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_i           (start_i),
        .slide_ok_i        (slide_ok_i),
        .tgt_m_i           (tgt_m_i),
        .tgt_n_i           (tgt_n_i),
        .tgt_pl_i          (tgt_pl_i),
        .disable_i         (disable_i),
        .pll_lock_i        (pll_lock_i),
        .ramp_done_i       (ramp_done_i),
        .ramp_err_i        (ramp_err_i),
        .nlo_cur_i         (nlo_n[0]),
        .nlo_new_i         (nlo_n[1]),
        .tmo_i             (tmo),
        .tmr_run_o         (tmr_run),
        .tmr_lock_o        (tmr_lock),
        .cur_m_o           (cur_m),
        .new_m_o           (new_m),
        .pll_en_o          (pll_en_o),
        .pll_iddq_o        (pll_iddq_o),
        .pll_lockdet_off_o (pll_lockdet_off_o),
        .pll_vco_sel_o     (pll_vco_sel_o),
        .vco_div_o         (vco_div_o),
        .coeff_o           (coeff_o),
        .ramp_req_o        (ramp_req_o),
        .ramp_n_o          (ramp_n_o),
        .busy_o            (busy_o),
        .done_o            (done_o),
        .err_o             (err_o)
    );
endmodule

// File: rtl/pll_seq_chk.sv
`timescale 1ns/1ps
// Cycle-level invariants of the sequencer, bound to the top module.
// Assumes the PLL keeps lock asserted while it stays enabled.
module pll_seq_chk
    import pll_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               pll_lock_i,
    input logic               pll_en_o,
    input logic               pll_vco_sel_o,
    input logic [DIV_W-1:0]   vco_div_o,
    input logic [COEFF_W-1:0] coeff_o,
    input logic               ramp_req_o,
    input logic [N_W-1:0]     ramp_n_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               err_o
);
    // M and PL fields move only while the PLL is disabled.
    assert_mpl_only_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({coeff_o[PL_LSB +: PL_W], coeff_o[M_LSB +: M_W]}) |-> !pll_en_o);

    // N moves on a running PLL only together with a rising ramp request.
    assert_n_only_by_ramp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(coeff_o[N_LSB +: N_W]) && pll_en_o) |-> $rose(ramp_req_o));

    // A pending request keeps its target until it is withdrawn.
    assert_ramp_target_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_req_o |=> (!ramp_req_o || $stable(ramp_n_o)));

    // Re-enable happens only from bypass with the 1:2 divider in place.
    assert_enable_in_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en_o) |-> (!pll_vco_sel_o && vco_div_o == DIV_1TO2));

    // VCO reselected only on a locked, enabled PLL, still divided by two.
    assert_vco_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_vco_sel_o) |-> (pll_lock_i && pll_en_o && vco_div_o == DIV_1TO2));

    // Requests to the ramp controller only inside a sequence.
    assert_ramp_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_req_o |-> busy_o);

    // Completion is a lone pulse outside the busy window.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // The error flag drops only when a start was presented.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $past(start_i));
endmodule

bind pll_reprog_seq pll_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .pll_lock_i    (pll_lock_i),
    .pll_en_o      (pll_en_o),
    .pll_vco_sel_o (pll_vco_sel_o),
    .vco_div_o     (vco_div_o),
    .coeff_o       (coeff_o),
    .ramp_req_o    (ramp_req_o),
    .ramp_n_o      (ramp_n_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
// Bench: models the PLL lock and the ramp controller, sweeps M, PL and the
// slide flag, then injects ramp errors, ramp hangs and lock failures.
module sim_pll_reprog_seq;
    localparam int LOCK_DLY = 4;
    localparam int RAMP_DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, slide_ok_i = 1'b0, disable_i = 1'b0;
    logic [7:0]  tgt_m_i = '0, tgt_n_i = '0;
    logic [5:0]  tgt_pl_i = '0;
    logic        pll_lock_i = 1'b0, ramp_done_i = 1'b0, ramp_err_i = 1'b0;
    logic        pll_en_o, pll_iddq_o, pll_lockdet_off_o, pll_vco_sel_o;
    logic [5:0]  vco_div_o;
    logic [21:0] coeff_o;
    logic        ramp_req_o, busy_o, done_o, err_o;
    logic [7:0]  ramp_n_o;

    always #2.5 clk = ~clk;

    pll_reprog_seq #(.CYC_PER_US(2), .LOCK_TMO_US(20), .RAMP_TMO_US(10)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .slide_ok_i(slide_ok_i),
        .tgt_m_i(tgt_m_i), .tgt_n_i(tgt_n_i), .tgt_pl_i(tgt_pl_i),
        .disable_i(disable_i), .pll_lock_i(pll_lock_i),
        .ramp_done_i(ramp_done_i), .ramp_err_i(ramp_err_i),
        .pll_en_o(pll_en_o), .pll_iddq_o(pll_iddq_o),
        .pll_lockdet_off_o(pll_lockdet_off_o), .pll_vco_sel_o(pll_vco_sel_o),
        .vco_div_o(vco_div_o), .coeff_o(coeff_o), .ramp_req_o(ramp_req_o),
        .ramp_n_o(ramp_n_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

    int n_chk = 0, n_fail = 0, cyc = 0;

    // PLL model: lock after LOCK_DLY enabled cycles unless blocked.
    logic lock_block = 1'b0;
    int   lcnt = 0;
    always @(posedge clk) begin
        if (!pll_en_o) begin lcnt <= 0; pll_lock_i <= 1'b0; end
        else if (lock_block) pll_lock_i <= 1'b0;
        else if (lcnt == LOCK_DLY) pll_lock_i <= 1'b1;
        else lcnt <= lcnt + 1;
    end

    // Ramp controller model: 0 answers done, 1 answers error, 2 never answers.
    int rmode = 0, rcnt = 0;
    always @(posedge clk) begin
        if (!ramp_req_o || ramp_done_i || ramp_err_i) begin
            rcnt <= 0; ramp_done_i <= 1'b0; ramp_err_i <= 1'b0;
        end else if (rcnt == RAMP_DLY) begin
            if (rmode == 0) ramp_done_i <= 1'b1;
            if (rmode == 1) ramp_err_i  <= 1'b1;
        end else rcnt <= rcnt + 1;
    end

    // Event monitor sampled on the falling edge.
    int          m_rcnt, m_en_rise, m_byp, m_vrise, m_done, m_done_wide;
    int          m_rlog [8];
    logic [21:0] m_coeff_en;
    logic [5:0]  m_div_en, m_div_byp, m_div_vrise;
    logic        m_vsel_en, m_lock_vrise;
    logic        p_req = 0, p_en = 0, p_vsel = 0, p_done = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (ramp_req_o && !p_req) begin
                if (m_rcnt < 8) m_rlog[m_rcnt] = int'(ramp_n_o);
                m_rcnt++;
            end
            if (pll_en_o && !p_en) begin
                m_en_rise++; m_coeff_en = coeff_o; m_div_en = vco_div_o;
                m_vsel_en = pll_vco_sel_o;
            end
            if (!pll_vco_sel_o && p_vsel) begin m_byp++; m_div_byp = vco_div_o; end
            if (pll_vco_sel_o && !p_vsel) begin
                m_vrise++; m_lock_vrise = pll_lock_i; m_div_vrise = vco_div_o;
            end
            if (done_o) m_done++;
            if (done_o && p_done) m_done_wide++;
        end
        p_req = ramp_req_o; p_en = pll_en_o; p_vsel = pll_vco_sel_o; p_done = done_o;
    end

    task automatic clr_mon();
        m_rcnt = 0; m_en_rise = 0; m_byp = 0; m_vrise = 0; m_done = 0; m_done_wide = 0;
        for (int i = 0; i < 8; i++) m_rlog[i] = -1;
        m_coeff_en = '0; m_div_en = '0; m_div_byp = '0; m_div_vrise = '0;
        m_vsel_en = 1'b0; m_lock_vrise = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nlo(input int m);
        int q = (m * 1000 + 11) / 12;
        return (q > 255) ? 255 : q;
    endfunction

    function automatic int pack(input int m, input int n, input int pl);
        return (pl << 16) | (n << 8) | m;
    endfunction

    // Bench view of the PLL state.
    int cur_en = 0, cur_m = 0, cur_n = 0, cur_pl = 0;

    // Issue one request (start or disable), optionally poke it while busy, wait for done.
    task automatic issue(input bit dis, input int m, input int n, input int pl,
                         input bit slide, input bit poke);
        @(posedge clk); #1;
        clr_mon();
        if (dis) disable_i = 1'b1;
        else begin
            start_i = 1'b1; slide_ok_i = slide;
            tgt_m_i = 8'(m); tgt_n_i = 8'(n); tgt_pl_i = 6'(pl);
        end
        @(posedge clk); #1;
        start_i = 1'b0; disable_i = 1'b0;
        if (poke) begin
            @(posedge clk); #1; @(posedge clk); #1;
            check(busy_o == 1'b1, "R12 busy during sequence", int'(busy_o), 1);
            start_i = 1'b1; disable_i = 1'b1; slide_ok_i = 1'b0;
            tgt_m_i = 8'd9; tgt_n_i = 8'd200; tgt_pl_i = 6'd7;
            @(posedge clk); #1;
            start_i = 1'b0; disable_i = 1'b0;
        end
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if (m_done > 0) break;
        end
        repeat (3) @(posedge clk);
        #1;
        check(m_done == 1 && m_done_wide == 0, "R12 single done pulse", m_done, 1);
        check(busy_o == 1'b0, "R12 idle after done", int'(busy_o), 0);
    endtask

    task automatic check_ramps(input string req, input int cnt, input int e0, input int e1);
        check(m_rcnt == cnt, req, m_rcnt, cnt);
        if (cnt > 0) check(m_rlog[0] == e0, req, m_rlog[0], e0);
        if (cnt > 1) check(m_rlog[1] == e1, req, m_rlog[1], e1);
    endtask

    // Successful program with the expected path computed from the bench state.
    task automatic prog_ok(input int m, input int n, input int pl, input bit slide);
        int ec = 0;
        int ex[2] = '{-1, -1};
        bit fast = slide && cur_en == 1 && m == cur_m && pl == cur_pl;
        if (fast) begin
            if (n != cur_n) begin ex[ec] = n; ec++; end
        end else begin
            if (slide && cur_en == 1 && nlo(cur_m) != cur_n) begin ex[ec] = nlo(cur_m); ec++; end
            if (slide && nlo(m) != n) begin ex[ec] = n; ec++; end
        end
        issue(1'b0, m, n, pl, slide, 1'b0);
        if (fast) begin
            check_ramps("R2 slide-only ramp list", ec, ex[0], ex[1]);
            check(m_en_rise == 0, "R2 no relock on slide path", m_en_rise, 0);
        end else begin
            check_ramps("R4 R8 ramp list on relock path", ec, ex[0], ex[1]);
            check(m_en_rise == 1, "R5 single re-enable", m_en_rise, 1);
            check(int'(m_coeff_en) == pack(m, slide ? nlo(m) : n, pl),
                  "R6 coefficient word at enable", int'(m_coeff_en), pack(m, slide ? nlo(m) : n, pl));
            check(m_div_en == 6'd2 && !m_vsel_en, "R5 bypass and div2 at enable",
                  int'(m_div_en), 2);
            if (m_byp > 0) check(m_div_byp == 6'd2, "R5 div2 before bypass", int'(m_div_byp), 2);
            check(m_vrise == 1 && m_lock_vrise && m_div_vrise == 6'd2,
                  "R7 VCO reselected under lock at div2", int'(m_div_vrise), 2);
        end
        check(int'(coeff_o) == pack(m, n, pl), "R3 final coefficient word",
              int'(coeff_o), pack(m, n, pl));
        check(pll_en_o && pll_vco_sel_o && vco_div_o == 6'd0 && !pll_iddq_o
              && !pll_lockdet_off_o && !err_o, "R7 final controls", int'(vco_div_o), 0);
        cur_en = 1; cur_m = m; cur_n = n; cur_pl = pl;
    endtask

    // Disable sequence with the expected ramp computed from the bench state.
    task automatic disable_ok();
        int ec = (cur_en == 1 && nlo(cur_m) != cur_n) ? 1 : 0;
        int was_en = cur_en;
        issue(1'b1, 0, 0, 0, 1'b0, 1'b0);
        check_ramps("R11 disable ramp list", ec, nlo(cur_m), -1);
        check(!pll_en_o && !pll_vco_sel_o, "R11 off and bypassed", int'(pll_en_o), 0);
        if (was_en == 1) begin
            check(int'(coeff_o[15:8]) == nlo(cur_m), "R11 N parked at n_lo",
                  int'(coeff_o[15:8]), nlo(cur_m));
            cur_n = nlo(cur_m);
        end
        cur_en = 0;
    endtask

    initial begin : wdog
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        clr_mon();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values.
        check(!pll_en_o && pll_iddq_o && pll_lockdet_off_o && !pll_vco_sel_o,
              "R1 reset PLL controls", int'({pll_en_o, pll_iddq_o, pll_lockdet_off_o, pll_vco_sel_o}), 6);
        check(vco_div_o == 6'd0 && coeff_o == 22'd0, "R1 reset divider and coefficients",
              int'(coeff_o), 0);
        check(!ramp_req_o && !busy_o && !done_o && !err_o, "R1 reset status",
              int'({ramp_req_o, busy_o, done_o, err_o}), 0);

        // Sweep: slide flag, M (covers n_lo saturation), PL, then an N-only change.
        for (int s = 1; s >= 0; s--) begin
            for (int m = 1; m <= 4; m++) begin
                for (int p = 1; p <= 3; p += 2) begin
                    prog_ok(m, 100 + 20 * m + p, p, s[0]);
                    prog_ok(m, 60 + 10 * m + p, p, s[0]);
                end
            end
        end
        // R2: same coefficients again, no ramp at all.
        prog_ok(cur_m, cur_n, cur_pl, 1'b1);
        // R12: requests poked mid-sequence are ignored.
        issue(1'b0, 2, 150, 5, 1'b1, 1'b1);
        check(int'(coeff_o) == pack(2, 150, 5) && pll_en_o, "R12 poke ignored",
              int'(coeff_o), pack(2, 150, 5));
        cur_en = 1; cur_m = 2; cur_n = 150; cur_pl = 5;

        // R9: ramp error on the slide-down step; retry relocks without sliding.
        rmode = 1;
        issue(1'b0, 3, 120, 5, 1'b1, 1'b0);
        check_ramps("R9 one failed ramp before retry", 1, nlo(2), -1);
        check(m_en_rise == 1 && int'(m_coeff_en) == pack(3, 120, 5),
              "R9 retry writes final N", int'(m_coeff_en), pack(3, 120, 5));
        check(!err_o && int'(coeff_o) == pack(3, 120, 5), "R9 retry succeeds", int'(err_o), 0);
        cur_m = 3; cur_n = 120; cur_pl = 5;

        // R9: hung ramp on the slide-only path times out and relocks.
        rmode = 2;
        issue(1'b0, 3, 90, 5, 1'b1, 1'b0);
        check_ramps("R9 hung ramp target", 1, 90, -1);
        check(m_en_rise == 1 && int'(m_coeff_en) == pack(3, 90, 5) && !err_o,
              "R9 timeout retry relocks", int'(m_coeff_en), pack(3, 90, 5));
        rmode = 0;
        cur_n = 90;

        // R10: lock never comes; both attempts fail, error is sticky.
        lock_block = 1'b1;
        issue(1'b0, 1, 200, 1, 1'b1, 1'b0);
        check_ramps("R9 slide-down before lock failure", 1, nlo(3), -1);
        check(m_en_rise == 2 && int'(m_coeff_en) == pack(1, 200, 1),
              "R9 second attempt without slide", int'(m_coeff_en), pack(1, 200, 1));
        check(err_o && !pll_vco_sel_o, "R10 error after lock timeout", int'(err_o), 1);
        repeat (10) @(posedge clk);
        #1 check(err_o == 1'b1, "R10 error stays set", int'(err_o), 1);
        lock_block = 1'b0;
        cur_en = 1; cur_m = 1; cur_n = 200; cur_pl = 1;
        prog_ok(2, 180, 1, 1'b0);
        check(err_o == 1'b0, "R10 cleared by next start", int'(err_o), 0);

        // R11: disable from enabled, then from disabled, then bring up again.
        disable_ok();
        disable_ok();
        prog_ok(4, 250, 2, 1'b1);
        disable_ok();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule